// File: doc/BRIEF.md
# Transmit Payload Input Interface (Serial or Nibble-Parallel)

This block takes outbound payload data from system-side equipment and hands it to a downstream framer as one bit per transmit clock, paired with a bit-valid strobe. A static select input picks the interface. With the select low, one bit is taken from the serial data input on every transmit clock edge. With the select high, the block generates a nibble clock at one quarter of the transmit clock and takes a 4-bit nibble once per nibble period. The nibble is sampled at a fixed phase, the third transmit clock edge after the nibble clock rises. The captured nibble is then shifted out most significant bit first.

In nibble mode the block also counts nibbles within a frame of `FRAME_BITS` bits. It raises a frame-end flag for the whole nibble period that carries the last nibble of each frame, which tells the system side to begin the next frame. The transmit clock has already been chosen outside the block (local timing or loop timing), so the block sees one clock only. The reset is asynchronous and active low, and it is expected to be released in step with the clock. The select input is meant to stay constant during operation; if it changes, the block restarts as it would after a reset.

Top module: `tx_payload_in`

## Requirements
- R1: When `sel_nibble` is low, `nib_data_i` has no effect on any output. When `sel_nibble` is high, `ser_data_i` has no effect on any output.
- R2: Serial mode (`sel_nibble` low). From the first clock edge after reset, each clock edge loads `ser_data_i` into `pay_bit_o` and sets `pay_vld_o` high. `pay_vld_o` is low before that first edge.
- R3: In nibble mode, `nib_clk_o` has a period of four clocks: high for two clocks, then low for two. It is high in the very first cycle after reset. In serial mode it is always low.
- R4: In nibble mode, `nib_data_i` is sampled only on the third rising clock edge after the cycle in which `nib_clk_o` rose, which is the edge that ends the first low cycle of `nib_clk_o`. Values present on other edges are ignored.
- R5: Each sampled nibble appears on `pay_bit_o` over the next four clock cycles, bit 3 first and bit 0 last, with `pay_vld_o` high. In nibble mode `pay_vld_o` stays low until the first capture.
- R6: Nibble periods are counted from 0, starting with the period that begins at reset. `frame_end_o` is high for all four clocks of period number FRAME_BITS/4 − 1 and low in every other period. The pattern repeats every FRAME_BITS/4 periods.
- R7: In serial mode `frame_end_o` is always low.
- R8: While reset is asserted, `pay_vld_o` is low and `frame_end_o` is low. In nibble mode `nib_clk_o` is high, because the phase counter sits at the start of a period.
- R9: A change of `sel_nibble` is detected on the next clock edge. After that edge, the block is in exactly the state it would have after a reset in the new mode: phase, frame position and output shifter are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit timing clock, already selected between local and loop timing |
| tx_rst_n | input | 1 | Asynchronous active-low reset, released in step with `tx_clk` |
| sel_nibble | input | 1 | Static interface select: 0 serial, 1 nibble-parallel |
| ser_data_i | input | 1 | Serial payload data |
| nib_data_i | input | 4 | Nibble-parallel payload data, bit 3 sent first |
| nib_clk_o | output | 1 | Nibble clock, one quarter of `tx_clk` in nibble mode |
| frame_end_o | output | 1 | High during the nibble period of the last nibble of a frame |
| pay_bit_o | output | 1 | Payload bit to the framer |
| pay_vld_o | output | 1 | Qualifies `pay_bit_o` |

## Verification
Assertions check on every cycle that:
- in serial mode each clock edge moves the serial input onto the payload output with valid high;
- each nibble capture puts bit 3 of the sampled nibble on the output at the next edge;
- the frame-end flag rises only at the start of a nibble period;
- the nibble clock holds high for a second cycle after it rises;
- the capture never happens while the nibble clock is high;
- the frame position stays inside the frame.

Only the bench scenarios can show the rest:
- the exact capture edge, by changing the nibble input on every cycle;
- the full MSB-first order across four cycles;
- the frame-end period number and its repetition over two frames;
- that the unused input in each mode has no effect;
- that a change of mode restarts everything as a reset would.

// File: rtl/txp_pkg.sv
package txp_pkg;
  // Position inside one nibble period; nibble clock is high in the first two.
  typedef enum logic [1:0] {
    PH_HI0 = 2'd0,
    PH_HI1 = 2'd1,
    PH_LO0 = 2'd2,
    PH_LO1 = 2'd3
  } phase_t;
endpackage

// File: rtl/txp_phase_gen.sv
module txp_phase_gen
  import txp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  output phase_t phase_o,
  output logic   cap_o,
  output logic   end_o
);
  phase_t ph_q, ph_d;

  always_comb begin
    if (clr) begin
      ph_d = PH_HI0;
    end else begin
      case (ph_q)
        PH_HI0:  ph_d = PH_HI1;
        PH_HI1:  ph_d = PH_LO0;
        PH_LO0:  ph_d = PH_LO1;
        default: ph_d = PH_HI0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_HI0;
    else        ph_q <= ph_d;
  end

  assign phase_o = ph_q;
  // Edge closing PH_LO0 is the third edge after the period started.
  assign cap_o   = (ph_q == PH_LO0);
  assign end_o   = (ph_q == PH_LO1);
endmodule

// File: rtl/txp_frame_cnt.sv
module txp_frame_cnt #(
  parameter int NIBS = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic last_o
);
  localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign last_o = (idx_q == LAST_IDX);
  assign idx_en = clr || adv;

  always_comb begin
    idx_d = idx_q;
    if (clr)         idx_d = '0;
    else if (last_o) idx_d = '0;
    else             idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < NIBS)
    else $error("frame position beyond frame length");
endmodule

// File: rtl/txp_serializer.sv
module txp_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       nib_mode,
  input  logic       cap,
  input  logic       ser_in,
  input  logic [3:0] nib_in,
  output logic       bit_o,
  output logic       vld_o
);
  logic [3:0] sr_q, sr_d;
  logic       vld_q, vld_d;

  always_comb begin
    sr_d  = sr_q;
    vld_d = vld_q;
    if (clr) begin
      sr_d  = '0;
      vld_d = 1'b0;
    end else if (!nib_mode) begin
      sr_d  = {ser_in, 3'b000};
      vld_d = 1'b1;
    end else if (cap) begin
      sr_d  = nib_in;
      vld_d = 1'b1;
    end else begin
      sr_d  = {sr_q[2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      vld_q <= vld_d;
    end
  end

  assign bit_o = sr_q[3];
  assign vld_o = vld_q;

  p_serial_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_mode && !clr) |=> (bit_o == $past(ser_in) && vld_o))
    else $error("serial bit not forwarded");

  p_capture_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_mode && cap && !clr) |=> (bit_o == $past(nib_in[3]) && vld_o))
    else $error("captured nibble msb not on output");
endmodule

// File: rtl/tx_payload_in.sv
module tx_payload_in
  import txp_pkg::*;
#(
  parameter int FRAME_BITS = 1536
) (
  input  logic       tx_clk,
  input  logic       tx_rst_n,
  input  logic       sel_nibble,
  input  logic       ser_data_i,
  input  logic [3:0] nib_data_i,
  output logic       nib_clk_o,
  output logic       frame_end_o,
  output logic       pay_bit_o,
  output logic       pay_vld_o
);
  localparam int NIBS = FRAME_BITS / 4;

  generate
    if ((FRAME_BITS % 4) != 0 || NIBS < 2) begin : g_bad_len
      $error("FRAME_BITS must be a multiple of 4 and at least 8");
    end
  endgenerate

  logic   mode_q, mode_d;
  logic   armed_q, armed_d;
  logic   resync;
  phase_t ph;
  logic   cap, per_end, last_nib;

  // Mode change after the first edge acts as a reset of all counters.
  assign resync  = armed_q && (sel_nibble != mode_q);
  assign mode_d  = sel_nibble;
  assign armed_d = 1'b1;

  always_ff @(posedge tx_clk or negedge tx_rst_n) begin
    if (!tx_rst_n) begin
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  txp_phase_gen u_phase (
    .clk     (tx_clk),
    .rst_n   (tx_rst_n),
    .clr     (resync),
    .phase_o (ph),
    .cap_o   (cap),
    .end_o   (per_end)
  );

  txp_frame_cnt #(.NIBS(NIBS)) u_frame (
    .clk    (tx_clk),
    .rst_n  (tx_rst_n),
    .clr    (resync),
    .adv    (sel_nibble && per_end),
    .last_o (last_nib)
  );

  txp_serializer u_ser (
    .clk      (tx_clk),
    .rst_n    (tx_rst_n),
    .clr      (resync),
    .nib_mode (sel_nibble),
    .cap      (cap),
    .ser_in   (ser_data_i),
    .nib_in   (nib_data_i),
    .bit_o    (pay_bit_o),
    .vld_o    (pay_vld_o)
  );

  assign nib_clk_o   = sel_nibble && (ph == PH_HI0 || ph == PH_HI1);
  assign frame_end_o = sel_nibble && last_nib;

  p_eof_start_r6: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    ($rose(frame_end_o) && sel_nibble) |-> nib_clk_o)
    else $error("frame end rose away from period start");

  p_nibclk_high_r3: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    $rose(nib_clk_o) |=> (nib_clk_o || !sel_nibble))
    else $error("nibble clock high for one cycle only");

  p_cap_low_r4: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (cap && sel_nibble) |-> !nib_clk_o)
    else $error("capture while nibble clock high");
endmodule

// File: tb/test_tx_payload_in.sv
module test_tx_payload_in;
  localparam int FB = 32;
  localparam int N  = FB / 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel;
  logic       ser;
  logic [3:0] nib;
  logic       nib_clk, eof, pbit, pvld;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #10 clk = ~clk;

  tx_payload_in #(.FRAME_BITS(FB)) i_tx_payload_in (
    .tx_clk      (clk),
    .tx_rst_n    (rst_n),
    .sel_nibble  (sel),
    .ser_data_i  (ser),
    .nib_data_i  (nib),
    .nib_clk_o   (nib_clk),
    .frame_end_o (eof),
    .pay_bit_o   (pbit),
    .pay_vld_o   (pvld)
  );

  function automatic logic [3:0] fnib(int k);
    return 4'((k * 5 + k / 3 + 1) % 16);
  endfunction

  function automatic logic gser(int k);
    return 1'(((k * 3) >> 1) ^ (k >> 3));
  endfunction

  task automatic chk(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    sel   = mode;
    ser   = 1'b0;
    nib   = 4'h0;
    repeat (3) @(negedge clk);
    chk("R8 valid low in reset", pvld, 1'b0);
    chk("R8 frame end low in reset", eof, 1'b0);
    chk("R8 nibble clock in reset", nib_clk, mode);
    rst_n = 1'b1;
  endtask

  // Starts in cycle 0 of nibble mode (state as right after reset).
  task automatic run_nibble(int ncyc, string tag);
    for (int c = 0; c < ncyc; c++) begin
      chk({tag, " R3 nibble clock"}, nib_clk, (c % 4) < 2);
      chk({tag, " R6 frame end"}, eof, ((c / 4) % N) == N - 1);
      chk({tag, " R5 valid"}, pvld, c >= 3);
      if (c >= 3) begin
        int m, j;
        logic [3:0] exp_nib;
        m = (c - 3) / 4;
        j = (c - 3) % 4;
        exp_nib = fnib(4 * m + 2);
        chk({tag, " R4 R5 R1 bit order"}, pbit, exp_nib[3 - j]);
      end
      nib = fnib(c);
      ser = gser(c + 7);
      @(negedge clk);
    end
  endtask

  // Starts in cycle 0 of serial mode.
  task automatic run_serial(int ncyc, string tag);
    for (int c = 0; c < ncyc; c++) begin
      chk({tag, " R3 nibble clock low"}, nib_clk, 1'b0);
      chk({tag, " R7 frame end low"}, eof, 1'b0);
      chk({tag, " R2 valid"}, pvld, c >= 1);
      if (c >= 1) chk({tag, " R2 R1 serial bit"}, pbit, gser(c - 1));
      ser = gser(c);
      nib = fnib(c + 3);
      @(negedge clk);
    end
  endtask

  task automatic switch_mode(logic mode);
    sel = mode;
    ser = 1'b1;
    nib = 4'hF;
    @(negedge clk);
  endtask

  task automatic t_nibble_frames();
    do_reset(1'b1);
    run_nibble(4 * N * 2 + 12, "nibble");
  endtask

  task automatic t_to_serial();
    switch_mode(1'b0);
    run_serial(40, "R9 to serial");
  endtask

  task automatic t_to_nibble();
    switch_mode(1'b1);
    run_nibble(4 * N + 8, "R9 to nibble");
  endtask

  task automatic t_serial_reset();
    do_reset(1'b0);
    run_serial(24, "serial");
  endtask

  initial begin
    rst_n = 1'b0;
    sel   = 1'b1;
    ser   = 1'b0;
    nib   = 4'h0;
    t_nibble_frames();
    t_to_serial();
    t_to_nibble();
    t_serial_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule